// File: doc/BRIEF.md
# Synchronous SRAM read output stage

This block is the read-side output path of a synchronous burst SRAM. Each clock edge registers one command (read, write or deselect). The memory array then returns read data for the command that was just registered. A static mode input chooses how that data reaches the data bus:

- **Flow-through:** the data goes straight through, so it is visible in the cycle that follows the registering edge.
- **Pipelined:** the data is first captured by an output register, so it appears one cycle later.

Deselects and writes travel down the same command pipeline as reads. As a result, in pipelined mode the bus keeps driving for one full cycle after a deselect is registered, and it releases only after the second edge (dual-cycle deselect). A registered write frees the bus at once, so write data can use the common I/O lines. An asynchronous output enable gates the drive-enable combinationally. Whenever the stage is not driving, the data output reads as zero.

Top module: `sram_rd_out_stage`

## Requirements
- R1: With `pipe_mode_i` low (flow-through), after the edge that registers a read, `dq_o` equals the current `rd_data_i` and `dq_oe_o` is high (given `oe_i` high) in that same cycle.
- R2: With `pipe_mode_i` high (pipelined), the data supplied on `rd_data_i` for a read is captured at the following edge. It is presented on `dq_o` with `dq_oe_o` high one cycle later than in flow-through mode.
- R3: In pipelined mode a registered deselect keeps the previous read on the bus for one full cycle, and `dq_oe_o` falls only after the second edge. In flow-through mode it falls after the first edge.
- R4: In the cycle after the edge that registers a write, `dq_oe_o` is low in both modes, even if a read is still in the pipeline.
- R5: `oe_i` low forces `dq_oe_o` low combinationally, without waiting for a clock edge. Raising it again restores the drive in the same cycle.
- R6: Whenever `dq_oe_o` is low, `dq_o` is all zeros.
- R7: `rst_ni` low asynchronously clears the pipeline and the output register to the deselected state: `dq_oe_o` low and `dq_o` zero.
- R8: The `cmd_i` encoding is 2'b00 deselect, 2'b01 read, 2'b10 write. The code 2'b11 behaves exactly as a deselect.
- R9: Changing `pipe_mode_i` takes effect combinationally on the next sample. In pipelined mode the output register holds the data captured for the most recent read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pipe_mode_i | input | 1 | 1 = pipelined output register, 0 = flow-through |
| cmd_i | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 deselect |
| rd_data_i | input | DATA_W | Array data for the command registered at the last edge |
| oe_i | input | 1 | Asynchronous output enable, active high |
| dq_o | output | DATA_W | Data bus value, zero when not driving |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions check the following on every clock edge:
- Writes never drive the bus.
- A non-read command turns the drive off by the second following edge.
- A low output enable keeps the bus off.
- An undriven bus reads zero.
- Pipelined data equals the array value one edge earlier.
- Flow-through data tracks the array input.

Some behaviours can only be shown by the bench's scenarios:
- The exact cycle of the one-cycle deselect hold.
- The one-cycle latency gap between the modes.
- Reserved-code handling.
- Reading of registered data across a mode switch.
- The mid-cycle response to the output enable and to an asynchronous reset.

// File: rtl/sram_out_pkg.sv
package sram_out_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;
endpackage

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe
  import sram_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  output logic       s1_rd_o,
  output logic       s1_wr_o,
  output logic       s2_rd_o
);
  logic s1_rd_q, s1_wr_q, s2_rd_q;

  // deselect, write and reserved all enter as "no read"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rd_q <= 1'b0;
      s1_wr_q <= 1'b0;
      s2_rd_q <= 1'b0;
    end else begin
      s1_rd_q <= (cmd_i == CMD_READ);
      s1_wr_q <= (cmd_i == CMD_WRITE);
      s2_rd_q <= s1_rd_q;
    end
  end

  assign s1_rd_o = s1_rd_q;
  assign s1_wr_o = s1_wr_q;
  assign s2_rd_o = s2_rd_q;
endmodule

// File: rtl/sram_out_reg.sv
module sram_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] sel_data_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (cap_en_i) data_q <= rd_data_i;
  end

  assign sel_data_o = pipe_mode_i ? data_q : rd_data_i;
endmodule

// File: rtl/sram_oe_gate.sv
module sram_oe_gate #(
  parameter int DATA_W = 32
) (
  input  logic              pipe_mode_i,
  input  logic              s1_rd_i,
  input  logic              s2_rd_i,
  input  logic              s1_wr_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] sel_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic rd_vld;

  always_comb begin
    rd_vld  = pipe_mode_i ? s2_rd_i : s1_rd_i;
    dq_oe_o = oe_i & rd_vld & ~s1_wr_i;
    dq_o    = dq_oe_o ? sel_data_i : '0;
  end
endmodule

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage
  import sram_out_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              s1_rd, s1_wr, s2_rd;
  logic [DATA_W-1:0] sel_data;

  sram_cmd_pipe u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_i),
    .s1_rd_o (s1_rd),
    .s1_wr_o (s1_wr),
    .s2_rd_o (s2_rd)
  );

  sram_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .cap_en_i    (s1_rd),
    .rd_data_i   (rd_data_i),
    .sel_data_o  (sel_data)
  );

  sram_oe_gate #(.DATA_W(DATA_W)) u_gate (
    .pipe_mode_i (pipe_mode_i),
    .s1_rd_i     (s1_rd),
    .s2_rd_i     (s2_rd),
    .s1_wr_i     (s1_wr),
    .oe_i        (oe_i),
    .sel_data_i  (sel_data),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );

  a_r4_write_frees_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WRITE) |=> !dq_oe_o);

  a_r3_off_by_second_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_READ) |=> ##1 !(pipe_mode_i && dq_oe_o));

  a_r5_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !dq_oe_o);

  a_r6_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));

  a_r2_pipe_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && dq_oe_o) |-> (dq_o == $past(rd_data_i)));

  a_r1_flow_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && dq_oe_o) |-> (dq_o == rd_data_i));

  a_r7_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!dq_oe_o && dq_o == '0));
endmodule

// File: tb/sram_rd_out_stage_tb.sv
module sram_rd_out_stage_tb;
  localparam int DW = 32;
  localparam int NV = 21;

  typedef struct packed {
    logic [1:0]    cmd;
    logic          mode;
    logic          oe;
    logic [DW-1:0] arr;
    logic          exp_oe;
    logic [DW-1:0] exp_dq;
    logic [7:0]    req;
  } vec_t;

  // cmd: 00 desel, 01 read, 10 write, 11 reserved
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b1, 1'b1, 32'hA1A1_0001, 1'b0, 32'h0,          8'd2}, // R2 first read, not yet out
    '{2'b01, 1'b1, 1'b1, 32'hA2A2_0002, 1'b1, 32'hA1A1_0001,  8'd2}, // R2 registered data
    '{2'b00, 1'b1, 1'b1, 32'h0,         1'b1, 32'hA2A2_0002,  8'd3}, // R3 desel held one cycle
    '{2'b00, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0,          8'd3}, // R3 off after 2nd edge
    '{2'b01, 1'b1, 1'b1, 32'hA3A3_0003, 1'b0, 32'h0,          8'd2}, // R2
    '{2'b10, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0,          8'd4}, // R4 write overrides read
    '{2'b01, 1'b1, 1'b1, 32'hA4A4_0004, 1'b0, 32'h0,          8'd4}, // R4 write bubble
    '{2'b01, 1'b1, 1'b0, 32'hA5A5_0005, 1'b0, 32'h0,          8'd5}, // R5 oe low
    '{2'b00, 1'b1, 1'b1, 32'h0,         1'b1, 32'hA5A5_0005,  8'd6}, // R6 data back
    '{2'b01, 1'b1, 1'b1, 32'hA6A6_0006, 1'b0, 32'h0,          8'd6}, // R6 zero when off
    '{2'b11, 1'b1, 1'b1, 32'h0,         1'b1, 32'hA6A6_0006,  8'd8}, // R8 reserved
    '{2'b01, 1'b1, 1'b1, 32'hA7A7_0007, 1'b0, 32'h0,          8'd8}, // R8 reserved = desel
    '{2'b01, 1'b0, 1'b1, 32'hB1B1_0011, 1'b1, 32'hB1B1_0011,  8'd1}, // R1 flow same cycle
    '{2'b00, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0,          8'd3}, // R3 flow off 1st edge
    '{2'b01, 1'b0, 1'b1, 32'hB2B2_0012, 1'b1, 32'hB2B2_0012,  8'd1}, // R1
    '{2'b10, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0,          8'd4}, // R4 flow write
    '{2'b01, 1'b0, 1'b0, 32'hB3B3_0013, 1'b0, 32'h0,          8'd5}, // R5 flow oe low
    '{2'b01, 1'b0, 1'b1, 32'hB4B4_0014, 1'b1, 32'hB4B4_0014,  8'd1}, // R1 back-to-back
    '{2'b01, 1'b1, 1'b1, 32'hC1C1_0021, 1'b1, 32'hB4B4_0014,  8'd9}, // R9 mode switch
    '{2'b00, 1'b1, 1'b1, 32'h0,         1'b1, 32'hC1C1_0021,  8'd9}, // R9
    '{2'b00, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0,          8'd3}  // R3
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pipe_mode_i = 1'b1;
  logic [1:0]    cmd_i = 2'b00;
  logic [DW-1:0] rd_data_i = '0;
  logic          oe_i = 1'b1;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sram_rd_out_stage #(.DATA_W(DW)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .cmd_i       (cmd_i),
    .rd_data_i   (rd_data_i),
    .oe_i        (oe_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );

  task automatic check(input string req, input logic exp_oe, input logic [DW-1:0] exp_dq);
    checks++;
    if (dq_oe_o !== exp_oe || dq_o !== exp_dq) begin
      failures++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe_o, dq_o, exp_oe, exp_dq);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // R7 reset state
    repeat (2) @(posedge clk_i);
    #2 check("R7", 1'b0, '0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cmd_i       = VECS[i].cmd;
      pipe_mode_i = VECS[i].mode;
      @(posedge clk_i);
      #1;
      rd_data_i = VECS[i].arr;
      oe_i      = VECS[i].oe;
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_oe, VECS[i].exp_dq);
    end

    // R5 asynchronous output enable within one cycle, pipelined
    cmd_i = 2'b01; pipe_mode_i = 1'b1;
    @(posedge clk_i); #1 rd_data_i = 32'hD0D0_0001;
    cmd_i = 2'b01;
    @(posedge clk_i); #1 rd_data_i = 32'hD0D0_0002;
    #1 check("R5 drive on", 1'b1, 32'hD0D0_0001);
    oe_i = 1'b0;
    #1 check("R5 async off", 1'b0, '0);
    oe_i = 1'b1;
    #1 check("R5 async on", 1'b1, 32'hD0D0_0001);

    // R7 asynchronous reset mid-cycle
    rst_ni = 1'b0;
    #1 check("R7 async clear", 1'b0, '0);
    @(posedge clk_i); #2 check("R7 held", 1'b0, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    cmd_i = 2'b00;
    @(posedge clk_i); #2 check("R7 after release", 1'b0, '0);

    finish_run();
  end
endmodule